// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight data registers arranged as a ring, each paired with a 2-bit tag. A 3-bit top pointer selects the current head. Every register access is relative to that head: position i of the stack lives in physical slot (top + i) mod 8. One command per cycle moves or rearranges entries:

- push an operand
- push a zero
- pop
- swap the head with another position
- copy the head into another position
- reset the whole ring to its initial state

The block also holds a 16-bit control word and a 16-bit status word. The status word receives fault flags, can have its exception bits cleared, and can take a copy of the top pointer on request. A push into an occupied slot is an overflow. A pop of an empty head is an underflow. Both are flagged, and neither changes the stack.

Arithmetic, number-format conversion and memory traffic belong to neighbouring logic. That logic supplies operands on the write-data input and reads stack positions through the combinational read ports.

Top module: `tag_reg_stack`

## Requirements

Tag encoding: 00 valid, 01 zero, 10 special, 11 empty. Status bit positions: bit 0 is the invalid-operation flag, bit 6 the stack-fault flag, bit 9 the overflow/underflow direction bit, bits 13:11 the top-pointer copy, and bit 15 busy. Opcodes on `cmd_op`: 0 push, 1 push-zero, 2 sync, 3 pop, 4 exchange, 5 copy, 6 init, 7 clear-exceptions.

- R1: After reset, and one cycle after an init command, the top pointer is 0, all eight tags read 11, the control word is 0x037F and the status word is 0.
- R2: A push that does not overflow decrements the top pointer modulo 8. It writes `wr_data` into the new head with tag 00, and each older entry moves from position i to position i+1.
- R3: A push (plain or zero) whose target slot, (top-1) mod 8, is not tagged 11 is an overflow. It pulses `ovf_o` for one cycle, sets status bits 0, 6 and 9, and leaves the top pointer and all slots unchanged.
- R4: A pop whose head is not tagged 11 sets the head's tag to 11 and increments the top pointer modulo 8.
- R5: A pop of a head tagged 11 is an underflow. It pulses `unf_o` for one cycle, sets status bits 0 and 6, clears bit 9, and leaves the top pointer and all slots unchanged.
- R6: A push-zero behaves as a push, except that the new head holds 0 with tag 01.
- R7: Each read port r returns the value and tag of physical slot (top + `rd_idx[r]`) mod 8, combinationally.
- R8: Exchange swaps both the value and the tag of position 0 and position `cmd_idx` in one cycle. With `cmd_idx` = 0 it changes nothing.
- R9: Copy writes the value and tag of position 0 into position `cmd_idx`. Position 0 keeps its contents.
- R10: Clear-exceptions replaces the status word with its AND against 0x7F00.
- R11: Sync writes the top pointer into status bits 13:11 and keeps every other status bit.
- R12: `cw_we` loads `cw_wdata` into the control word on the next edge. Init takes priority over it.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | PTR_W | Stack-relative operand position for exchange and copy |
| wr_data | input | DATA_W | Operand for push |
| cw_we | input | 1 | Control word write enable |
| cw_wdata | input | 16 | Control word write value |
| rd_idx | input | NRD*PTR_W | Stack-relative index per read port, port r at bits r*PTR_W |
| rd_data | output | NRD*DATA_W | Value per read port |
| rd_tag | output | NRD*2 | Tag per read port |
| top_o | output | PTR_W | Current top pointer |
| cw_o | output | 16 | Control word |
| sw_o | output | 16 | Status word |
| ovf_o | output | 1 | Overflow pulse, one cycle after the faulting push |
| unf_o | output | 1 | Underflow pulse, one cycle after the faulting pop |

## Verification

Several behaviours are checked by the embedded properties on every cycle:

- the top pointer moving by exactly one on a clean push or pop
- the top pointer holding still on a fault, together with the fault pulse and status bits
- the init values
- the clear-exceptions mask
- the top-pointer copy into the status word
- the rule that the two write ports never target the same slot

Some behaviours only the directed scenarios can show, because they need the slot contents seen through the read ports:

- the relative-to-physical mapping
- the values and tags moved by exchange and copy
- zero tagging
- wrap-around of the pointer across slot 0
- the contents being left intact by a faulting command

The bench reads every stack position after every command.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [1:0] {
      TAG_VAL   = 2'b00,
      TAG_ZERO  = 2'b01,
      TAG_SPEC  = 2'b10,
      TAG_EMPTY = 2'b11
   } slot_tag_e;

   typedef enum logic [2:0] {
      OP_PUSH  = 3'd0,
      OP_PUSHZ = 3'd1,
      OP_SYNC  = 3'd2,
      OP_POP   = 3'd3,
      OP_XCHG  = 3'd4,
      OP_COPY  = 3'd5,
      OP_INIT  = 3'd6,
      OP_CLEX  = 3'd7
   } stk_op_e;

   localparam int          SW_IE     = 0;
   localparam int          SW_SF     = 6;
   localparam int          SW_C1     = 9;
   localparam int          SW_TOP_LO = 11;
   localparam logic [15:0] CW_INIT   = 16'h037F;
   localparam logic [15:0] SW_KEEP   = 16'h7F00;

endpackage

// File: rtl/stk_top_ptr.sv
module stk_top_ptr #(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec,
   input  logic             inc,
   input  logic             clr,
   output logic [PTR_W-1:0] top_o
);

   logic [PTR_W-1:0] top_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) top_q <= '0;
      else if (dec)      top_q <= top_q - PTR_W'(1);
      else if (inc)      top_q <= top_q + PTR_W'(1);
   end

   assign top_o = top_q;

   assert_one_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec, inc, clr}));

endmodule

// File: rtl/stk_slot_file.sv
module stk_slot_file
   import stk_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int PTR_W  = 3,
   parameter int NPORT  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_all,
   input  logic                      we_a,
   input  logic                      tag_only_a,
   input  logic [PTR_W-1:0]          addr_a,
   input  logic [DATA_W-1:0]         data_a,
   input  logic [1:0]                tag_a,
   input  logic                      we_b,
   input  logic [PTR_W-1:0]          addr_b,
   input  logic [DATA_W-1:0]         data_b,
   input  logic [1:0]                tag_b,
   input  logic [NPORT*PTR_W-1:0]    rd_addr,
   output logic [NPORT*DATA_W-1:0]   rd_data,
   output logic [NPORT*2-1:0]        rd_tag,
   output logic [(2**PTR_W)*2-1:0]   tag_flat
);

   localparam int DEPTH = 2 ** PTR_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("stk_slot_file: DATA_W must be positive");
   end
   if (NPORT < 1) begin : g_bad_ports
      $error("stk_slot_file: NPORT must be positive");
   end

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [1:0]        tag_q  [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            data_q[k] <= '0;
            tag_q[k]  <= TAG_EMPTY;
         end
      end else begin
         if (we_a) begin
            if (!tag_only_a) data_q[addr_a] <= data_a;
            tag_q[addr_a] <= tag_a;
         end
         if (we_b) begin
            data_q[addr_b] <= data_b;
            tag_q[addr_b]  <= tag_b;
         end
         if (clr_all) begin
            for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
         end
      end
   end

   for (genvar r = 0; r < NPORT; r++) begin : g_rd
      logic [PTR_W-1:0] a;
      assign a = rd_addr[r*PTR_W +: PTR_W];
      assign rd_data[r*DATA_W +: DATA_W] = data_q[a];
      assign rd_tag[r*2 +: 2]            = tag_q[a];
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_tagv
      assign tag_flat[k*2 +: 2] = tag_q[k];
   end

   assert_clr_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (&tag_flat));

   assert_port_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a && we_b) |-> (addr_a != addr_b));

endmodule

// File: rtl/stk_status.sv
module stk_status
   import stk_pkg::*;
#(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             clex,
   input  logic             sync,
   input  logic [PTR_W-1:0] top_in,
   input  logic             ovf,
   input  logic             unf,
   input  logic             cw_we,
   input  logic [15:0]      cw_wdata,
   output logic [15:0]      cw_o,
   output logic [15:0]      sw_o
);

   if (SW_TOP_LO + PTR_W > 15) begin : g_bad_ptr
      $error("stk_status: top pointer does not fit below the busy bit");
   end

   logic [15:0] cw_q, sw_q, sw_d;

   always_comb begin
      sw_d = sw_q;
      if (init) begin
         sw_d = '0;
      end else if (clex) begin
         sw_d = sw_q & SW_KEEP;
      end else if (ovf || unf) begin
         sw_d[SW_IE] = 1'b1;
         sw_d[SW_SF] = 1'b1;
         sw_d[SW_C1] = ovf;
      end else if (sync) begin
         sw_d[SW_TOP_LO +: PTR_W] = top_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cw_q <= CW_INIT;
         sw_q <= '0;
      end else begin
         sw_q <= sw_d;
         if (init)       cw_q <= CW_INIT;
         else if (cw_we) cw_q <= cw_wdata;
      end
   end

   assign cw_o = cw_q;
   assign sw_o = sw_q;

   assert_clex_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clex && !init) |=> (sw_o == ($past(sw_o) & 16'h7F00)));

   assert_init_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (cw_o == 16'h037F && sw_o == 16'h0000));

   assert_cw_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_we && !init) |=> (cw_o == $past(cw_wdata)));

endmodule

// File: rtl/tag_reg_stack.sv
module tag_reg_stack
   import stk_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int PTR_W  = 3,
   parameter int NRD    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [PTR_W-1:0]        cmd_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    cw_we,
   input  logic [15:0]             cw_wdata,
   input  logic [NRD*PTR_W-1:0]    rd_idx,
   output logic [NRD*DATA_W-1:0]   rd_data,
   output logic [NRD*2-1:0]        rd_tag,
   output logic [PTR_W-1:0]        top_o,
   output logic [15:0]             cw_o,
   output logic [15:0]             sw_o,
   output logic                    ovf_o,
   output logic                    unf_o
);

   localparam int DEPTH = 2 ** PTR_W;
   localparam int NINT  = 2;
   localparam int NPORT = NRD + NINT;

   if (PTR_W < 1 || PTR_W > 4) begin : g_bad_ptr
      $error("tag_reg_stack: PTR_W must be 1 to 4");
   end
   if (NRD < 1) begin : g_bad_rd
      $error("tag_reg_stack: at least one read port is required");
   end

   stk_op_e            op;
   logic [PTR_W-1:0]   top, top_m1, sel;
   logic [DEPTH*2-1:0] tag_flat;
   logic [NPORT*PTR_W-1:0]  rd_addr_all;
   logic [NPORT*DATA_W-1:0] rd_data_all;
   logic [NPORT*2-1:0]      rd_tag_all;
   logic [DATA_W-1:0]  d_top, d_sel;
   logic [1:0]         t_top, t_sel, t_tgt;
   logic               is_push, is_pop, ovf, unf, push_ok, pop_ok;
   logic               do_xchg, do_copy, do_init, do_clex, do_sync;
   logic               we_a, tag_only_a, we_b;
   logic [PTR_W-1:0]   addr_a, addr_b;
   logic [DATA_W-1:0]  data_a, data_b;
   logic [1:0]         tag_a, tag_b;
   logic               ovf_q, unf_q;

   assign op     = stk_op_e'(cmd_op);
   assign top_m1 = top - PTR_W'(1);
   assign sel    = top + cmd_idx;

   // physical addresses: external ports first, then head and selected slot
   for (genvar r = 0; r < NRD; r++) begin : g_map
      assign rd_addr_all[r*PTR_W +: PTR_W] = top + rd_idx[r*PTR_W +: PTR_W];
   end
   assign rd_addr_all[NRD*PTR_W +: PTR_W]     = top;
   assign rd_addr_all[(NRD+1)*PTR_W +: PTR_W] = sel;

   assign rd_data = rd_data_all[NRD*DATA_W-1:0];
   assign rd_tag  = rd_tag_all[NRD*2-1:0];
   assign d_top   = rd_data_all[NRD*DATA_W +: DATA_W];
   assign d_sel   = rd_data_all[(NRD+1)*DATA_W +: DATA_W];
   assign t_top   = rd_tag_all[NRD*2 +: 2];
   assign t_sel   = rd_tag_all[(NRD+1)*2 +: 2];
   assign t_tgt   = tag_flat[top_m1*2 +: 2];

   assign is_push = cmd_valid && (op == OP_PUSH || op == OP_PUSHZ);
   assign is_pop  = cmd_valid && (op == OP_POP);
   assign ovf     = is_push && (t_tgt != TAG_EMPTY);
   assign unf     = is_pop && (t_top == TAG_EMPTY);
   assign push_ok = is_push && !ovf;
   assign pop_ok  = is_pop && !unf;
   assign do_xchg = cmd_valid && (op == OP_XCHG) && (cmd_idx != '0);
   assign do_copy = cmd_valid && (op == OP_COPY) && (cmd_idx != '0);
   assign do_init = cmd_valid && (op == OP_INIT);
   assign do_clex = cmd_valid && (op == OP_CLEX);
   assign do_sync = cmd_valid && (op == OP_SYNC);

   always_comb begin
      we_a       = 1'b0;
      tag_only_a = 1'b0;
      addr_a     = top;
      data_a     = d_sel;
      tag_a      = t_sel;
      we_b       = 1'b0;
      addr_b     = sel;
      data_b     = d_top;
      tag_b      = t_top;
      if (push_ok) begin
         we_a   = 1'b1;
         addr_a = top_m1;
         data_a = (op == OP_PUSHZ) ? '0 : wr_data;
         tag_a  = (op == OP_PUSHZ) ? TAG_ZERO : TAG_VAL;
      end else if (pop_ok) begin
         we_a       = 1'b1;
         tag_only_a = 1'b1;
         tag_a      = TAG_EMPTY;
      end else if (do_xchg) begin
         we_a = 1'b1;
         we_b = 1'b1;
      end else if (do_copy) begin
         we_b = 1'b1;
      end
   end

   stk_slot_file #(.DATA_W(DATA_W), .PTR_W(PTR_W), .NPORT(NPORT)) u_slots (
      .clk(clk), .rst_n(rst_n), .clr_all(do_init),
      .we_a(we_a), .tag_only_a(tag_only_a), .addr_a(addr_a), .data_a(data_a), .tag_a(tag_a),
      .we_b(we_b), .addr_b(addr_b), .data_b(data_b), .tag_b(tag_b),
      .rd_addr(rd_addr_all), .rd_data(rd_data_all), .rd_tag(rd_tag_all),
      .tag_flat(tag_flat)
   );

   stk_top_ptr #(.PTR_W(PTR_W)) u_top (
      .clk(clk), .rst_n(rst_n), .dec(push_ok), .inc(pop_ok), .clr(do_init), .top_o(top)
   );

   stk_status #(.PTR_W(PTR_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .init(do_init), .clex(do_clex), .sync(do_sync),
      .top_in(top), .ovf(ovf), .unf(unf), .cw_we(cw_we), .cw_wdata(cw_wdata),
      .cw_o(cw_o), .sw_o(sw_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= ovf;
         unf_q <= unf;
      end
   end

   assign ovf_o = ovf_q;
   assign unf_o = unf_q;
   assign top_o = top;

   assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok) |=> (top_o == $past(top_o) - PTR_W'(1)));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (ovf_o && top_o == $past(top_o) && sw_o[0] && sw_o[6] && sw_o[9]));

   assert_pop_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> (top_o == $past(top_o) + PTR_W'(1)));

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> (unf_o && top_o == $past(top_o) && sw_o[0] && sw_o[6] && !sw_o[9]));

   assert_init_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
      do_init |=> (top_o == '0));

   assert_sync_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
      do_sync |=> (sw_o[SW_TOP_LO +: PTR_W] == $past(top_o)));

endmodule

// File: tb/sim_tag_reg_stack.sv
`timescale 1ns/1ps
module sim_tag_reg_stack;

   localparam int DW = 64;
   localparam int PW = 3;
   localparam int NR = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [PW-1:0] cmd_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic          cw_we = 1'b0;
   logic [15:0]   cw_wdata = '0;
   logic [NR*PW-1:0] rd_idx = '0;
   logic [NR*DW-1:0] rd_data;
   logic [NR*2-1:0]  rd_tag;
   logic [PW-1:0] top_o;
   logic [15:0]   cw_o, sw_o;
   logic          ovf_o, unf_o;

   tag_reg_stack #(.DATA_W(DW), .PTR_W(PW), .NRD(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
      .wr_data(wr_data), .cw_we(cw_we), .cw_wdata(cw_wdata), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_tag(rd_tag), .top_o(top_o), .cw_o(cw_o), .sw_o(sw_o),
      .ovf_o(ovf_o), .unf_o(unf_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DW-1:0] mdata [8];
   logic [1:0]    mtag  [8];
   logic [2:0]    mtop;
   logic [15:0]   msw, mcw;
   logic          movf, munf;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "top", 64'(top_o), 64'(mtop));
      chk(req, "sw", 64'(sw_o), 64'(msw));
      chk(req, "cw", 64'(cw_o), 64'(mcw));
      chk(req, "ovf", 64'(ovf_o), 64'(movf));
      chk(req, "unf", 64'(unf_o), 64'(munf));
      for (int i = 0; i < 8; i++) begin
         logic [2:0] j;
         j = 3'(i + 3);
         rd_idx = {j, 3'(i)};
         #0.1;
         chk("R7", "rd0 data", rd_data[DW-1:0], mdata[3'(mtop + 3'(i))]);
         chk("R7", "rd0 tag", 64'(rd_tag[1:0]), 64'(mtag[3'(mtop + 3'(i))]));
         chk("R7", "rd1 data", rd_data[2*DW-1:DW], mdata[3'(mtop + j)]);
         chk("R7", "rd1 tag", 64'(rd_tag[3:2]), 64'(mtag[3'(mtop + j)]));
      end
   endtask

   task automatic model_init();
      for (int k = 0; k < 8; k++) mtag[k] = 2'b11;
      mtop = 0; msw = 16'h0000; mcw = 16'h037F;
   endtask

   // drive one command, update the reference, check after the edge
   task automatic run(input logic [2:0] op, input logic [2:0] idx, input logic [63:0] d, input string req);
      logic [2:0] t1, s;
      logic [63:0] td;
      logic [1:0]  tt;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; wr_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      movf = 1'b0; munf = 1'b0;
      s = 3'(mtop + idx);
      case (op)
         3'd0, 3'd1: begin
            t1 = 3'(mtop - 3'd1);
            if (mtag[t1] != 2'b11) begin
               movf = 1'b1; msw[0] = 1'b1; msw[6] = 1'b1; msw[9] = 1'b1;
            end else begin
               mtop = t1;
               mdata[t1] = (op == 3'd1) ? 64'd0 : d;
               mtag[t1]  = (op == 3'd1) ? 2'b01 : 2'b00;
            end
         end
         3'd2: msw[13:11] = mtop;
         3'd3: begin
            if (mtag[mtop] == 2'b11) begin
               munf = 1'b1; msw[0] = 1'b1; msw[6] = 1'b1; msw[9] = 1'b0;
            end else begin
               mtag[mtop] = 2'b11;
               mtop = 3'(mtop + 3'd1);
            end
         end
         3'd4: begin
            td = mdata[s]; tt = mtag[s];
            mdata[s] = mdata[mtop]; mtag[s] = mtag[mtop];
            mdata[mtop] = td; mtag[mtop] = tt;
         end
         3'd5: begin
            mdata[s] = mdata[mtop]; mtag[s] = mtag[mtop];
         end
         3'd6: model_init();
         default: msw = msw & 16'h7F00;
      endcase
      check_all(req);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 8; k++) mdata[k] = '0;
      model_init();
      movf = 1'b0; munf = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // fill the ring: wraps from slot 0 down to 7, 6, ...
      for (int k = 0; k < 8; k++)
         run(3'd0, 3'd0, 64'h0101_0101_0101_0101 * 64'(k + 1) + 64'(k), "R2");
      run(3'd0, 3'd0, 64'hDEAD_BEEF_0000_0001, "R3");
      run(3'd1, 3'd0, 64'd0, "R3");
      run(3'd7, 3'd0, 64'd0, "R10");
      run(3'd2, 3'd0, 64'd0, "R11");
      for (int k = 0; k < 8; k++) run(3'd4, 3'(k), 64'd0, "R8");
      run(3'd5, 3'd3, 64'd0, "R9");
      run(3'd5, 3'd0, 64'd0, "R9");
      run(3'd4, 3'd5, 64'd0, "R8");

      // drain and underflow
      for (int k = 0; k < 8; k++) run(3'd3, 3'd0, 64'd0, "R4");
      run(3'd3, 3'd0, 64'd0, "R5");
      run(3'd7, 3'd0, 64'd0, "R10");

      // zero push, mixed push, sync, exchange with zero-tagged entry
      run(3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
      run(3'd0, 3'd0, 64'h1234_5678_9ABC_DEF0, "R2");
      run(3'd2, 3'd0, 64'd0, "R11");
      run(3'd4, 3'd1, 64'd0, "R8");
      run(3'd3, 3'd0, 64'd0, "R4");

      // control word load, then init overrides it
      @(negedge clk);
      cw_we = 1'b1; cw_wdata = 16'h0A5C;
      @(negedge clk);
      cw_we = 1'b0; mcw = 16'h0A5C; movf = 1'b0; munf = 1'b0;
      check_all("R12");
      @(negedge clk);
      cw_we = 1'b1; cw_wdata = 16'h1111;
      cmd_valid = 1'b1; cmd_op = 3'd6;
      @(negedge clk);
      cw_we = 1'b0; cmd_valid = 1'b0;
      model_init();
      check_all("R12");
      run(3'd6, 3'd0, 64'd0, "R1");

      // sweep every depth: push k, then pop all, with sync at each depth
      for (int n = 1; n <= 8; n++) begin
         for (int k = 0; k < n; k++) run(3'd0, 3'd0, 64'(n * 100 + k), "R2");
         run(3'd2, 3'd0, 64'd0, "R11");
         for (int k = 0; k < n; k++) run(3'd3, 3'd0, 64'd0, "R4");
      end
      run(3'd3, 3'd0, 64'd0, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule